// File: doc/BRIEF.md
# Mask-Selected DAC Channel Combiner

This block takes the output streams of up to four up-converter channels, each carried as a signed I and Q sample, and forms the data words for two DAC outputs, called lane A and lane B. Each lane has its own source mask and its own disable bit. A shared mode field decides how the mask bits are read. In bypass mode a lane passes one raw input stream through. In real mode a lane adds together any subset of the channel streams. In complex mode the low half of the mask selects real parts and the high half selects imaginary parts, so that one DAC carries the real signal and the other carries the imaginary signal.

Each lane's sum is formed with guard bits and then clamped symmetrically to the output width. The result is held in an output register that loads only on cycles where the sample strobe is high. This strobe marks the sample boundary: changes to mask, mode or disable settings become visible at the next strobed edge and not before. The block uses an asynchronous active-low reset that is released synchronously inside the block.

Top module: `chc_combiner`

## Requirements
- R1: With mode = 0 (bypass), a lane outputs the I part of the lowest-numbered channel whose mask bit is set. No summing takes place. For example, mask 0x1 on lane A and 0x2 on lane B route channel 0 to A and channel 1 to B.
- R2: With mode = 1 (real), a lane outputs the sum of the I parts of every channel whose mask bit is set. Masks 0x1, 0x3, 0x7 and 0xF add the first one, two, three or four channels.
- R3: With mode = 2 (complex), mask bits 0 and 1 add the I parts of channels 0 and 1, and mask bits 2 and 3 add the Q parts of channels 0 and 1. For example, A = 0x1 and B = 0x4 put channel 0's real part on A and its imaginary part on B.
- R4: A lane whose mask is 0x0 outputs zero in every mode.
- R5: Each lane result is clamped to the range ±(2^(OW-1)−1) and never wraps. The most negative code is never produced.
- R6: An output changes only at a rising clock edge where sample_en is high. At that edge it shows the result for the inputs and settings present at that edge. When sample_en is low, the output holds its value.
- R7: When a lane's disable bit is high, that lane outputs zero whatever its mask and mode.
- R8: Swapping the two mask values swaps the two outputs. Equal masks and equal disable bits give identical outputs.
- R9: Mode = 3 is reserved. In that mode both lanes output zero.
- R10: While rst_n is low, both outputs are zero at once, without waiting for a clock edge. After release they stay zero until the first strobed edge that follows the internal release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sample-boundary strobe; loads the output registers |
| chan_i | input | NCH*DW | I parts of the channels, channel k at bits [k*DW +: DW] |
| chan_q | input | NCH*DW | Q parts of the channels, same packing as chan_i |
| mode | input | 2 | 0 bypass, 1 real, 2 complex, 3 reserved |
| mask_a | input | NCH | Source mask for lane A |
| mask_b | input | NCH | Source mask for lane B |
| off_a | input | 1 | Forces lane A to zero |
| off_b | input | 1 | Forces lane B to zero |
| dac_a | output | OW | Lane A data, signed |
| dac_b | output | OW | Lane B data, signed |

## Verification
The bench uses the default parameters: NCH = 4, DW = 16, OW = 16 and GUARD = 2. Because the input and output widths are equal, a sum of two or more near-full-scale channels goes past the output range. A single input of −32768 also reaches the symmetric clamp. Both clamp limits can therefore be reached with simple directed vectors. Four channels fill the complex mask exactly: two real selectors and two imaginary selectors. Seeded random vectors across all four modes then exercise masks with sparse bits and masks whose lowest set bit is not bit 0.

// File: rtl/chc_pkg.sv
`timescale 1ns/1ps
package chc_pkg;
  typedef enum logic [1:0] {
    CM_BYPASS = 2'd0,
    CM_REAL   = 2'd1,
    CM_CPLX   = 2'd2,
    CM_RSVD   = 2'd3
  } comb_mode_e;
endpackage

// File: rtl/chc_rst_sync.sv
`timescale 1ns/1ps
module chc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/chc_lane_sel.sv
`timescale 1ns/1ps
module chc_lane_sel
  import chc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input  logic [NCH*DW-1:0]    chan_i,
  input  logic [NCH*DW-1:0]    chan_q,
  input  logic [NCH-1:0]       mask,
  input  comb_mode_e           mode,
  input  logic                 lane_off,
  output logic signed [DW-1:0] opnd [NCH]
);
  localparam int HALF = NCH / 2;

  // Lowest set mask bit, isolated, for bypass routing
  logic [NCH-1:0] first_hot;
  always_comb begin
    first_hot = mask & (~mask + NCH'(1));
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic signed [DW-1:0] re_k;
    logic signed [DW-1:0] cplx_k;
    logic signed [DW-1:0] pick_k;

    assign re_k = $signed(chan_i[k*DW +: DW]);

    if (k < HALF) begin : g_re
      assign cplx_k = $signed(chan_i[k*DW +: DW]);
    end else begin : g_im
      assign cplx_k = $signed(chan_q[(k-HALF)*DW +: DW]);
    end

    always_comb begin
      pick_k = '0;
      case (mode)
        CM_BYPASS: if (first_hot[k]) pick_k = re_k;
        CM_REAL:   if (mask[k])      pick_k = re_k;
        CM_CPLX:   if (mask[k])      pick_k = cplx_k;
        default:   pick_k = '0;
      endcase
      if (lane_off) pick_k = '0;
    end

    assign opnd[k] = pick_k;
  end
endmodule

// File: rtl/chc_sum_sat.sv
`timescale 1ns/1ps
module chc_sum_sat #(
  parameter int NCH   = 4,
  parameter int DW    = 16,
  parameter int OW    = 16,
  parameter int GUARD = 2
) (
  input  logic signed [DW-1:0] opnd [NCH],
  output logic signed [OW-1:0] sat_out
);
  localparam int SW = DW + GUARD;
  localparam int LIM = (1 << (OW-1)) - 1;
  localparam logic signed [SW-1:0] POS_LIM = SW'(LIM);
  localparam logic signed [SW-1:0] NEG_LIM = -POS_LIM;

  logic signed [SW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NCH; k++) begin
      acc = acc + SW'(opnd[k]);
    end
  end

  always_comb begin
    if (acc > POS_LIM)      sat_out = POS_LIM[OW-1:0];
    else if (acc < NEG_LIM) sat_out = NEG_LIM[OW-1:0];
    else                    sat_out = acc[OW-1:0];
  end
endmodule

// File: rtl/chc_out_reg.sv
`timescale 1ns/1ps
module chc_out_reg #(
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          load,
  input  logic [OW-1:0] d,
  output logic [OW-1:0] q
);
  logic [OW-1:0] q_nxt;

  always_comb begin
    q_nxt = load ? d : q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/chc_combiner.sv
`timescale 1ns/1ps
module chc_combiner
  import chc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DW    = 16,
  parameter int OW    = 16,
  parameter int GUARD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic [NCH*DW-1:0] chan_i,
  input  logic [NCH*DW-1:0] chan_q,
  input  logic [1:0]        mode,
  input  logic [NCH-1:0]    mask_a,
  input  logic [NCH-1:0]    mask_b,
  input  logic              off_a,
  input  logic              off_b,
  output logic [OW-1:0]     dac_a,
  output logic [OW-1:0]     dac_b
);
  localparam int NLANE = 2;

  logic       rst_q;
  comb_mode_e mode_e;
  logic [NCH-1:0] lane_mask [NLANE];
  logic           lane_off  [NLANE];
  logic [OW-1:0]  lane_q    [NLANE];

  assign mode_e       = comb_mode_e'(mode);
  assign lane_mask[0] = mask_a;
  assign lane_mask[1] = mask_b;
  assign lane_off[0]  = off_a;
  assign lane_off[1]  = off_b;

  chc_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic signed [DW-1:0] opnd [NCH];
    logic signed [OW-1:0] sat_v;

    chc_lane_sel #(.NCH(NCH), .DW(DW)) u_sel (
      .chan_i   (chan_i),
      .chan_q   (chan_q),
      .mask     (lane_mask[g]),
      .mode     (mode_e),
      .lane_off (lane_off[g]),
      .opnd     (opnd)
    );

    chc_sum_sat #(.NCH(NCH), .DW(DW), .OW(OW), .GUARD(GUARD)) u_sum (
      .opnd    (opnd),
      .sat_out (sat_v)
    );

    chc_out_reg #(.OW(OW)) u_reg (
      .clk   (clk),
      .rst_q (rst_q),
      .load  (sample_en),
      .d     (sat_v),
      .q     (lane_q[g])
    );
  end

  assign dac_a = lane_q[0];
  assign dac_b = lane_q[1];
endmodule

// File: rtl/chc_combiner_chk.sv
`timescale 1ns/1ps
module chc_combiner_chk #(
  parameter int NCH = 4,
  parameter int OW  = 16
) (
  input logic           clk,
  input logic           rst_q,
  input logic           sample_en,
  input logic [1:0]     mode,
  input logic [NCH-1:0] mask_a,
  input logic [NCH-1:0] mask_b,
  input logic           off_a,
  input logic           off_b,
  input logic [OW-1:0]  dac_a,
  input logic [OW-1:0]  dac_b
);
  localparam logic [OW-1:0] MIN_CODE = {1'b1, {(OW-1){1'b0}}};

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_q)
    !$past(sample_en) |-> ($stable(dac_a) && $stable(dac_b)));

  p_zero_mask_r4: assert property (@(posedge clk) disable iff (!rst_q)
    $past(sample_en && mask_a == '0) |-> dac_a == '0);

  p_off_r7: assert property (@(posedge clk) disable iff (!rst_q)
    $past(sample_en && off_b) |-> dac_b == '0);

  p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_q)
    $past(sample_en && mode == 2'd3) |-> (dac_a == '0 && dac_b == '0));

  p_same_mask_r8: assert property (@(posedge clk) disable iff (!rst_q)
    $past(sample_en && mask_a == mask_b && off_a == off_b) |-> dac_a == dac_b);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (dac_a != MIN_CODE) && (dac_b != MIN_CODE));
endmodule

bind chc_combiner chc_combiner_chk #(.NCH(NCH), .OW(OW)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .sample_en (sample_en),
  .mode      (mode),
  .mask_a    (mask_a),
  .mask_b    (mask_b),
  .off_a     (off_a),
  .off_b     (off_b),
  .dac_a     (dac_a),
  .dac_b     (dac_b)
);

// File: tb/tb_chc_combiner.sv
`timescale 1ns/1ps
module tb_chc_combiner;
  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam int OW  = 16;
  localparam int LIM = 32767;

  typedef struct {
    int    ea;
    int    eb;
    string tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sample_en = 1'b0;
  logic [NCH*DW-1:0] chan_i = '0;
  logic [NCH*DW-1:0] chan_q = '0;
  logic [1:0]        mode = 2'd0;
  logic [NCH-1:0]    mask_a = '0;
  logic [NCH-1:0]    mask_b = '0;
  logic              off_a = 1'b0;
  logic              off_b = 1'b0;
  logic [OW-1:0]     dac_a;
  logic [OW-1:0]     dac_b;

  int vi [NCH];
  int vq [NCH];
  item_t sb_q [$];
  int last_a = 0;
  int last_b = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chc_combiner #(.NCH(NCH), .DW(DW), .OW(OW), .GUARD(2)) dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .chan_i(chan_i), .chan_q(chan_q), .mode(mode),
    .mask_a(mask_a), .mask_b(mask_b), .off_a(off_a), .off_b(off_b),
    .dac_a(dac_a), .dac_b(dac_b)
  );

  function automatic int clamp(int v);
    if (v > LIM)  return LIM;
    if (v < -LIM) return -LIM;
    return v;
  endfunction

  function automatic int model(logic [1:0] m, logic [3:0] mk, logic off);
    int s = 0;
    if (off || m == 2'd3) return 0;
    if (m == 2'd0) begin
      for (int k = NCH-1; k >= 0; k--) if (mk[k]) s = vi[k];
    end else if (m == 2'd1) begin
      for (int k = 0; k < NCH; k++) if (mk[k]) s += vi[k];
    end else begin
      if (mk[0]) s += vi[0];
      if (mk[1]) s += vi[1];
      if (mk[2]) s += vq[0];
      if (mk[3]) s += vq[1];
    end
    return clamp(s);
  endfunction

  task automatic check(string tag, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  task automatic set_ch(int a0, int a1, int a2, int a3, int b0, int b1, int b2, int b3);
    vi[0] = a0; vi[1] = a1; vi[2] = a2; vi[3] = a3;
    vq[0] = b0; vq[1] = b1; vq[2] = b2; vq[3] = b3;
  endtask

  task automatic step(logic en, logic [1:0] m, logic [3:0] ma, logic [3:0] mb,
                      logic oa, logic ob, string tag);
    item_t it;
    @(negedge clk);
    for (int k = 0; k < NCH; k++) begin
      chan_i[k*DW +: DW] = DW'(vi[k]);
      chan_q[k*DW +: DW] = DW'(vq[k]);
    end
    sample_en = en; mode = m; mask_a = ma; mask_b = mb; off_a = oa; off_b = ob;
    if (en) begin
      last_a = model(m, ma, oa);
      last_b = model(m, mb, ob);
    end
    it.ea = last_a; it.eb = last_b; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares each cycle's outputs against the scoreboard head
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, "dac_a", int'($signed(dac_a)), it.ea);
        check(it.tag, "dac_b", int'($signed(dac_b)), it.eb);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    set_ch(0, 0, 0, 0, 0, 0, 0, 0);
    #1;
    // R10: asynchronous reset state
    check("R10", "dac_a", int'(dac_a), 0);
    check("R10", "dac_b", int'(dac_b), 0);
    repeat (3) @(negedge clk);
    sample_en = 1'b1; mask_a = 4'h1; mode = 2'd1;
    set_ch(5, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R10", "dac_a", int'(dac_a), 0);
    sample_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: bypass routing
    set_ch(100, -200, 300, -400, 7, 8, 9, 10);
    step(1, 2'd0, 4'h1, 4'h2, 0, 0, "R1");
    step(1, 2'd0, 4'hE, 4'hC, 0, 0, "R1");
    step(1, 2'd0, 4'h8, 4'hF, 0, 0, "R1");
    // R2: real summing
    step(1, 2'd1, 4'h1, 4'h3, 0, 0, "R2");
    step(1, 2'd1, 4'h7, 4'hF, 0, 0, "R2");
    step(1, 2'd1, 4'hA, 4'h5, 0, 0, "R2");
    // R3: complex
    set_ch(1000, 2000, 3, 4, -1500, 2500, 5, 6);
    step(1, 2'd2, 4'h1, 4'h4, 0, 0, "R3");
    step(1, 2'd2, 4'h3, 4'hC, 0, 0, "R3");
    step(1, 2'd2, 4'h2, 4'h8, 0, 0, "R3");
    // R4: empty mask in every mode
    step(1, 2'd0, 4'h0, 4'h1, 0, 0, "R4");
    step(1, 2'd1, 4'h0, 4'h0, 0, 0, "R4");
    step(1, 2'd2, 4'h3, 4'h0, 0, 0, "R4");
    // R5: symmetric clamp
    set_ch(30000, 30000, 30000, 30000, -32768, -32768, 0, 0);
    step(1, 2'd1, 4'hF, 4'h3, 0, 0, "R5");
    set_ch(-32768, -32768, -32768, -32768, -32768, -32768, 0, 0);
    step(1, 2'd1, 4'hF, 4'h1, 0, 0, "R5");
    step(1, 2'd0, 4'h1, 4'h2, 0, 0, "R5");
    step(1, 2'd2, 4'hF, 4'hC, 0, 0, "R5");
    // R6: hold while strobe is low, then apply new settings at the strobe
    set_ch(11, 22, 33, 44, 0, 0, 0, 0);
    step(1, 2'd1, 4'h3, 4'h4, 0, 0, "R6");
    set_ch(-1, -2, -3, -4, 9, 9, 9, 9);
    step(0, 2'd2, 4'hF, 4'h1, 1, 0, "R6");
    step(0, 2'd0, 4'h8, 4'h8, 0, 1, "R6");
    step(1, 2'd1, 4'hC, 4'h9, 0, 0, "R6");
    // R7: disable bits
    set_ch(500, 600, 700, 800, 50, 60, 0, 0);
    step(1, 2'd1, 4'hF, 4'hF, 1, 0, "R7");
    step(1, 2'd2, 4'h3, 4'hC, 0, 1, "R7");
    // R8: swap and equal masks
    step(1, 2'd2, 4'hC, 4'h3, 0, 0, "R8");
    step(1, 2'd1, 4'h6, 4'h6, 0, 0, "R8");
    step(1, 2'd0, 4'h2, 4'h1, 0, 0, "R8");
    // R9: reserved mode
    step(1, 2'd3, 4'hF, 4'h1, 0, 0, "R9");

    // Random vectors over all modes
    for (int n = 0; n < 60; n++) begin
      logic [1:0] m;
      string tg;
      for (int k = 0; k < NCH; k++) begin
        vi[k] = int'($signed(16'($urandom)));
        vq[k] = int'($signed(16'($urandom)));
        if (n % 4 == 0) begin
          vi[k] = vi[k] / 64;
          vq[k] = vq[k] / 64;
        end
      end
      m = 2'($urandom);
      tg = (m == 2'd0) ? "R1" : (m == 2'd1) ? "R2" : (m == 2'd2) ? "R3" : "R9";
      step(1'($urandom_range(0, 3) != 0), m, 4'($urandom), 4'($urandom),
           1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 7) == 0), tg);
    end

    // R10: reset in the middle of operation
    set_ch(1234, 0, 0, 0, 0, 0, 0, 0);
    step(1, 2'd1, 4'h1, 4'h1, 0, 0, "R10");
    step(0, 2'd1, 4'h1, 4'h1, 0, 0, "R10");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10", "dac_a", int'(dac_a), 0);
    check("R10", "dac_b", int'(dac_b), 0);
    @(negedge clk);
    rst_n = 1'b1;
    last_a = 0; last_b = 0;
    repeat (4) @(negedge clk);
    step(0, 2'd1, 4'h1, 4'h1, 0, 0, "R10");
    step(1, 2'd1, 4'h1, 4'h0, 0, 0, "R10");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule